// File: doc/BRIEF.md
# Tiered Reset Request Router

This block turns two reset requests, one from a debounced external reset pin and one from the processor's system-reset request, into active-high resets for four clock domains: the main core domain, the real-time-clock domain, the low-power timer domain and the debug domain. Each request source has its own 3-bit level selector. The selector decides how deep the reset goes, from blocking the request entirely up to resetting every domain. A configuration strap decides whether the pin source obeys its selector or always performs the deepest reset.

Software programs both selectors and a 2-bit scratch field through a 32-bit write/read register port. An accepted request drives the chosen domain resets for a fixed stretch of clock cycles, and both edges of that stretch are clocked. A power-on reset forces every domain into reset and returns every field to its initial value. Only the deepest level clears the mode fields. Lighter levels leave the software configuration in place, so it survives them.

Top module: `tier_reset_router`

## Requirements
- R1: The register holds the scratch field in bits 25:24, the pin level selector in bits 14:12 and the system-reset level selector in bits 10:8. A write loads exactly these bits. Every other bit reads 0, whatever was written, so writing all ones reads back 0x0300_7700.
- R2: While power-on reset is high, all four domain resets are high and the register reads 0x0000_4200 (pin level 4, system-reset level 2, scratch 0). After power-on reset is released, the outputs stay high and fall at the 16th rising clock edge.
- R3: The level code selects the reset domains as follows:
  - 1 resets the core only.
  - 2 resets the core and real-time-clock domains.
  - 4 resets all four domains.
  
  The output vector {debug, timer, rtc, core} is therefore 0001, 0011 or 1111.
- R4: A level code of 0, 3, 5, 6 or 7 blocks its request. No domain reset is asserted, and for a pin request the scratch field is kept.
- R5: With the soft-pin strap high, a pin request uses the pin level selector. With the strap low, a pin request always resets all four domains, whatever the selector holds.
- R6: The router samples the request inputs on the rising clock edge. It asserts the selected resets at the edge that first samples a request input high after it was low. The resets stay high for exactly 16 clock cycles. A request accepted during a stretch adds its domains to those already in reset and restarts the 16-cycle count.
- R7: When both sources raise a request at the same edge, the union of their selected domains is reset.
- R8: An accepted request at level 4 resets both level selectors to 4 and 2. A request at level 1 or 2 leaves the register unchanged.
- R9: The scratch field has no effect on the resets. An accepted pin request of any level clears it. A system-reset request keeps it, even at level 4.
- R10: A request input held high does not trigger again. The stretch ends after 16 cycles even while the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| pin_req_i | input | 1 | Debounced external reset pin request, active high |
| sys_req_i | input | 1 | Processor system-reset request, active high |
| soft_pin_strap_i | input | 1 | Strap that enables the pin level selector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| rst_core_o | output | 1 | Core domain reset |
| rst_rtc_o | output | 1 | Real-time-clock domain reset |
| rst_tmr_o | output | 1 | Low-power timer domain reset |
| rst_dbg_o | output | 1 | Debug domain reset |

## Verification
The bench goes after the following corner cases:
- **Reserved codes.** It drives the codes 3, 5, 6 and 7 through random writes. A decoder that fell through to a partial reset would assert the core reset where none is expected.
- **Strap-low full reset.** It sets the strap low while the pin selector holds 0. A router that obeyed the selector anyway would block a reset that must be full.
- **Restart during a stretch.** It raises a second request in the middle of a stretch. A design that did not merge the masks would drop the real-time-clock reset, and one that did not reload the counter would release it too early.
- **Held request and register side effects.** It holds a request line high to expose level-triggered retriggering. It also checks that a level-4 system reset keeps the scratch field while a pin reset clears it, which catches a wrongly shared clearing path.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned DOM_N      = 4;
    localparam int unsigned LVL_W      = 3;
    localparam int unsigned SCR_W      = 2;
    localparam int unsigned NSRC       = 2;

    // domain bit positions in a mask
    localparam int unsigned DOM_CORE   = 0;
    localparam int unsigned DOM_RTC    = 1;
    localparam int unsigned DOM_TMR    = 2;
    localparam int unsigned DOM_DBG    = 3;

    // source indices
    localparam int unsigned SRC_PIN    = 0;
    localparam int unsigned SRC_SYS    = 1;

    // register field positions (low bit of each field)
    localparam int unsigned SCR_LSB    = 24;
    localparam int unsigned PINLV_LSB  = 12;
    localparam int unsigned SYSLV_LSB  = 8;

    typedef logic [DOM_N-1:0] dom_mask_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_OFF      = 3'd0,
        LVL_CORE     = 3'd1,
        LVL_CORE_RTC = 3'd2,
        LVL_ALL      = 3'd4
    } lvl_code_e;

    localparam lvl_t PINLV_INIT = 3'd4;
    localparam lvl_t SYSLV_INIT = 3'd2;

    typedef struct packed {
        logic [SCR_W-1:0] scratch;
        lvl_t             pin_lvl;
        lvl_t             sys_lvl;
    } cfg_t;

    localparam logic [REG_W-1:0] REG_MASK =
        ({{(REG_W-SCR_W){1'b0}}, {SCR_W{1'b1}}} << SCR_LSB) |
        ({{(REG_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << PINLV_LSB) |
        ({{(REG_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << SYSLV_LSB);

endpackage

// File: rtl/rtr_edge_detect.sv
module rtr_edge_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/rtr_level_decode.sv
module rtr_level_decode
    import rtr_pkg::*;
(
    input  lvl_t      lvl_i,
    output dom_mask_t mask_o,
    output logic      full_o
);

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        case (lvl_i)
            LVL_CORE: begin
                mask_o[DOM_CORE] = 1'b1;
            end
            LVL_CORE_RTC: begin
                mask_o[DOM_CORE] = 1'b1;
                mask_o[DOM_RTC]  = 1'b1;
            end
            LVL_ALL: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default: begin
                mask_o = '0;   // off and unassigned codes block
            end
        endcase
    end

endmodule

// File: rtl/rtr_stretch.sv
module rtr_stretch
    import rtr_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 16
) (
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      load_i,
    input  dom_mask_t load_mask_i,
    output dom_mask_t mask_o
);

    localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        dom_mask_t        mask;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.mask = st_q.mask | load_mask_i;
            st_d.cnt  = CNT_LOAD;
        end else if (st_q.cnt > CNT_ONE) begin
            st_d.cnt  = st_q.cnt - CNT_ONE;
        end else if (st_q.cnt == CNT_ONE) begin
            st_d.cnt  = '0;
            st_d.mask = '0;
        end
        mask_o = st_q.mask;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            st_q.mask <= '1;
            st_q.cnt  <= CNT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tier_reset_router.sv
module tier_reset_router
    import rtr_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 16
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              pin_req_i,
    input  logic              sys_req_i,
    input  logic              soft_pin_strap_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              rst_core_o,
    output logic              rst_rtc_o,
    output logic              rst_tmr_o,
    output logic              rst_dbg_o
);

    localparam cfg_t CFG_INIT = '{scratch: '0, pin_lvl: PINLV_INIT, sys_lvl: SYSLV_INIT};

    cfg_t           cfg_d, cfg_q;
    logic [NSRC-1:0] rise;
    lvl_t            eff_lvl  [NSRC];
    dom_mask_t       src_mask [NSRC];
    logic [NSRC-1:0] src_full;
    logic [NSRC-1:0] src_acc;
    logic            any_load;
    logic            any_full;
    dom_mask_t       load_mask;
    dom_mask_t       dom_rst;

    // request edge detection
    logic [NSRC-1:0] req_lvl;
    always_comb begin
        req_lvl          = '0;
        req_lvl[SRC_PIN] = pin_req_i;
        req_lvl[SRC_SYS] = sys_req_i;
    end

    rtr_edge_detect #(.N(NSRC)) u_edge (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .lvl_i  (req_lvl),
        .rise_o (rise)
    );

    // effective level per source (strap low forces pin to full)
    always_comb begin
        eff_lvl[SRC_PIN] = soft_pin_strap_i ? cfg_q.pin_lvl : lvl_t'(LVL_ALL);
        eff_lvl[SRC_SYS] = cfg_q.sys_lvl;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rtr_level_decode u_dec (
            .lvl_i  (eff_lvl[s]),
            .mask_o (src_mask[s]),
            .full_o (src_full[s])
        );
        assign src_acc[s] = rise[s] & (|src_mask[s]);
    end

    // combine accepted sources
    always_comb begin
        load_mask = '0;
        any_full  = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_acc[s]) begin
                load_mask = load_mask | src_mask[s];
                any_full  = any_full | src_full[s];
            end
        end
        any_load = |src_acc;
    end

    rtr_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .load_i      (any_load),
        .load_mask_i (load_mask),
        .mask_o      (dom_rst)
    );

    // control register next state
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i) begin
            cfg_d.scratch = reg_wdata_i[SCR_LSB   +: SCR_W];
            cfg_d.pin_lvl = reg_wdata_i[PINLV_LSB +: LVL_W];
            cfg_d.sys_lvl = reg_wdata_i[SYSLV_LSB +: LVL_W];
        end
        if (any_full) begin
            cfg_d.pin_lvl = PINLV_INIT;
            cfg_d.sys_lvl = SYSLV_INIT;
        end
        if (src_acc[SRC_PIN]) begin
            cfg_d.scratch = '0;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) cfg_q <= CFG_INIT;
        else       cfg_q <= cfg_d;
    end

    // read data and outputs
    always_comb begin
        reg_rdata_o                          = '0;
        reg_rdata_o[SCR_LSB   +: SCR_W]      = cfg_q.scratch;
        reg_rdata_o[PINLV_LSB +: LVL_W]      = cfg_q.pin_lvl;
        reg_rdata_o[SYSLV_LSB +: LVL_W]      = cfg_q.sys_lvl;
        rst_core_o = dom_rst[DOM_CORE];
        rst_rtc_o  = dom_rst[DOM_RTC];
        rst_tmr_o  = dom_rst[DOM_TMR];
        rst_dbg_o  = dom_rst[DOM_DBG];
    end

endmodule

// File: rtl/rtr_checker.sv
module rtr_checker
    import rtr_pkg::*;
(
    input logic             clk_i,
    input logic             por_i,
    input logic             pin_req_i,
    input logic             sys_req_i,
    input logic             soft_pin_strap_i,
    input logic             reg_wr_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             rst_core_o,
    input logic             rst_rtc_o,
    input logic             rst_tmr_o,
    input logic             rst_dbg_o
);

    logic [LVL_W-1:0] sys_lvl_rd;
    logic             sys_blocked;
    logic             all_rst;

    always_comb begin
        sys_lvl_rd  = reg_rdata_o[SYSLV_LSB +: LVL_W];
        sys_blocked = !(sys_lvl_rd == 3'd1 || sys_lvl_rd == 3'd2 || sys_lvl_rd == 3'd4);
        all_rst     = rst_core_o && rst_rtc_o && rst_tmr_o && rst_dbg_o;
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (por_i)
        (reg_rdata_o & ~REG_MASK) == '0);

    assert_core_cover_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_rtc_o || rst_tmr_o || rst_dbg_o) |-> rst_core_o);

    assert_tmr_dbg_pair_R3: assert property (@(posedge clk_i) disable iff (por_i)
        rst_tmr_o == rst_dbg_o);

    assert_block_sys_R4: assert property (@(posedge clk_i) disable iff (por_i)
        ($rose(sys_req_i) && !$rose(pin_req_i) && sys_blocked && !rst_core_o)
        |=> !rst_core_o);

    assert_strap_full_R5: assert property (@(posedge clk_i) disable iff (por_i)
        ($rose(pin_req_i) && !soft_pin_strap_i) |=> all_rst);

    assert_min_width_R6: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(rst_core_o) |=> rst_core_o);

    assert_keep_scratch_R9: assert property (@(posedge clk_i) disable iff (por_i)
        ($rose(sys_req_i) && !$rose(pin_req_i) && !reg_wr_i)
        |=> reg_rdata_o[SCR_LSB +: SCR_W] == $past(reg_rdata_o[SCR_LSB +: SCR_W]));

    assert_no_retrigger_R10: assert property (@(posedge clk_i) disable iff (por_i)
        (sys_req_i && $past(sys_req_i) && !$rose(pin_req_i) && !rst_core_o)
        |=> !rst_core_o);

endmodule

bind tier_reset_router rtr_checker u_chk (
    .clk_i            (clk_i),
    .por_i            (por_i),
    .pin_req_i        (pin_req_i),
    .sys_req_i        (sys_req_i),
    .soft_pin_strap_i (soft_pin_strap_i),
    .reg_wr_i         (reg_wr_i),
    .reg_rdata_o      (reg_rdata_o),
    .rst_core_o       (rst_core_o),
    .rst_rtc_o        (rst_rtc_o),
    .rst_tmr_o        (rst_tmr_o),
    .rst_dbg_o        (rst_dbg_o)
);

// File: tb/sim_tier_reset_router.sv
module sim_tier_reset_router;

    localparam logic [31:0] MASK = 32'h0300_7700;
    localparam logic [31:0] INIT = 32'h0000_4200;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        pin_req = 1'b0;
    logic        sys_req = 1'b0;
    logic        strap = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        r_core, r_rtc, r_tmr, r_dbg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_reg;

    always #5 clk = ~clk;

    tier_reset_router u0 (
        .clk_i            (clk),
        .por_i            (por),
        .pin_req_i        (pin_req),
        .sys_req_i        (sys_req),
        .soft_pin_strap_i (strap),
        .reg_wr_i         (wr),
        .reg_wdata_i      (wdata),
        .reg_rdata_o      (rdata),
        .rst_core_o       (r_core),
        .rst_rtc_o        (r_rtc),
        .rst_tmr_o        (r_tmr),
        .rst_dbg_o        (r_dbg)
    );

    function automatic logic [3:0] outs();
        return {r_dbg, r_tmr, r_rtc, r_core};
    endfunction

    // expected domain mask {dbg,tmr,rtc,core} for a level code
    function automatic logic [3:0] lvl_mask(logic [2:0] l);
        case (l)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [31:0] d);
        wr = 1'b1;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
        exp_reg = d & MASK;
    endtask

    // raise requests at a negedge, check the full stretch
    task automatic request(bit p, bit s, string tag);
        logic [2:0] pl;
        logic [2:0] sl;
        logic [3:0] mp, ms, m;
        bit         full;
        pl   = strap ? exp_reg[14:12] : 3'd4;
        sl   = exp_reg[10:8];
        mp   = p ? lvl_mask(pl) : 4'b0;
        ms   = s ? lvl_mask(sl) : 4'b0;
        m    = mp | ms;
        full = (mp == 4'hF) || (ms == 4'hF);
        if (full) exp_reg = (exp_reg & ~32'h0000_7700) | 32'h0000_4200;
        if (mp != 4'b0) exp_reg = exp_reg & ~32'h0300_0000;
        pin_req = p;
        sys_req = s;
        @(negedge clk);
        pin_req = 1'b0;
        sys_req = 1'b0;
        check({tag, " mask at first cycle"}, {28'b0, outs()}, {28'b0, m});
        check({tag, " register after request"}, rdata, exp_reg);
        if (m != 4'b0) begin
            wait_n(15);
            check({tag, " R6 mask at cycle 16"}, {28'b0, outs()}, {28'b0, m});
            wait_n(1);
        end else begin
            wait_n(16);
        end
        check({tag, " R6 released after 16"}, {28'b0, outs()}, 32'b0);
        wait_n(2);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        exp_reg = INIT;
        wait_n(3);
        // R2 during power-on reset
        check("R2 outputs during por", {28'b0, outs()}, 32'hF);
        check("R2 register during por", rdata, INIT);
        por = 1'b0;
        wait_n(15);
        check("R2 outputs 15 cycles after por", {28'b0, outs()}, 32'hF);
        wait_n(1);
        check("R2 outputs released after por", {28'b0, outs()}, 32'h0);

        // R1 reserved bits
        write_reg(32'hFFFF_FFFF);
        check("R1 readback of all ones", rdata, 32'h0300_7700);
        write_reg(32'h00AB_88FF);
        check("R1 reserved ignored", rdata, 32'h0);

        // R3 levels through the system source
        write_reg(32'h0000_0100);
        request(0, 1, "R3 level1");
        write_reg(32'h0000_0200);
        request(0, 1, "R3 level2 R8 keep");
        write_reg(32'h0300_1400);
        request(0, 1, "R3 level4 R9 keep scratch R8 clear");
        check("R9 scratch kept after full sys", rdata, 32'h0300_4200);

        // R4 blocked codes
        write_reg(32'h0000_0300);
        request(0, 1, "R4 code3");
        write_reg(32'h0200_0700);
        request(0, 1, "R4 code7");

        // R5 strap
        strap = 1'b0;
        write_reg(32'h0100_0200);
        request(1, 0, "R5 strap low forces full R9 clear");
        check("R9 scratch cleared by pin", rdata, 32'h0000_4200);
        strap = 1'b1;
        write_reg(32'h0200_0200);
        request(1, 0, "R5 strap high code0 blocks R4");
        check("R4 blocked pin keeps scratch", rdata, 32'h0200_0200);
        write_reg(32'h0100_2100);
        request(1, 0, "R5 strap high code2");

        // R7 simultaneous: blocked pin plus level2 sys
        write_reg(32'h0300_0200);
        request(1, 1, "R7 union blocked pin");
        write_reg(32'h0000_1200);
        request(1, 1, "R7 union level1 pin level2 sys");

        // R6 restart during a stretch
        write_reg(32'h0000_2100);
        exp_reg = 32'h0000_2100;
        sys_req = 1'b1;
        @(negedge clk);
        sys_req = 1'b0;
        check("R6 first request core", {28'b0, outs()}, 32'h1);
        wait_n(7);
        pin_req = 1'b1;
        @(negedge clk);
        pin_req = 1'b0;
        check("R6 merged mask", {28'b0, outs()}, 32'h3);
        wait_n(15);
        check("R6 restarted count still high", {28'b0, outs()}, 32'h3);
        wait_n(1);
        check("R6 restarted count released", {28'b0, outs()}, 32'h0);
        wait_n(2);

        // R10 held request
        write_reg(32'h0000_0100);
        sys_req = 1'b1;
        @(negedge clk);
        check("R10 held start", {28'b0, outs()}, 32'h1);
        wait_n(15);
        check("R10 held cycle 16", {28'b0, outs()}, 32'h1);
        wait_n(1);
        check("R10 held released", {28'b0, outs()}, 32'h0);
        wait_n(6);
        check("R10 held no retrigger", {28'b0, outs()}, 32'h0);
        sys_req = 1'b0;
        wait_n(2);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] d;
            int          sel;
            d     = $urandom();
            strap = 1'($urandom_range(0, 1));
            sel   = $urandom_range(1, 3);
            write_reg(d);
            check("R1 random readback", rdata, exp_reg);
            request(sel[0], sel[1], "R3 R4 R5 R7 R8 R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule